// File: doc/BRIEF.md
# Serial Configuration Word Receiver with Synchronized Divider Commit

This block takes configuration from a three-wire link (serial clock, serial data, strobe). It assembles 24-bit words, decodes the address at the top of each word, and drives the fields as parallel register outputs. Those outputs control a main fractional divider, a reference divider, an auxiliary divider, the lock indicator and a set of transmit controls. The serial pins are sampled in the system clock domain, so the serial clock must be much slower than `clk`.

The reference and auxiliary words take effect as soon as the strobe rises. The transmit-control word loads once for each strobe assertion. The main-ratio word is not applied at the strobe edge. It waits for a terminal-count pulse from the main divider, and that pulse must arrive while the strobe is still high. When it does, the new ratio is applied together with the compensation DAC value that an earlier reference word left in a staging register. From the strobe edge that latched a main-ratio word until the strobe falls, a speed-up request is raised for the loop charge pumps. The lock output selects and combines per-loop lock flags, and a section that is switched off counts as locked.

Top module: `prog_serial_regs`

## Requirements
- R1: After synchronous reset the outputs are as follows. `main_n`=512 and `ref_n`=4. `aux_n`=128. `fdac`=0. All other register fields are 0, and `speedup`=0.
- R2: A rising `ser_clk` shifts `ser_data` in only while `ser_strobe` is low. Bits arrive least significant first, so the last bit lands in bit 23. While the strobe is high, clock pulses do not change the assembled word. A later strobe rise with no new bits re-applies the same word.
- R3: Bits [23:22] of a word select how it is handled:
  - Address 00 is the main-ratio word: `main_fmod`=[21], `main_nf`=[20:18], `main_n`=[17:2].
  - Address 01 is the reference word: `ref_n`=[21:12], `ref_sel_main`=[11:10], `ref_sel_aux`=[9:8], with the DAC value in [7:0].
  - Address 10 is the auxiliary word: `aux_n`=[21:8], `cp_ratio`=[7:6], `lock_sel`=[5:4], `pwr_main`=[3], `pwr_aux`=[2].
  - When bits [23:21]=110 it is the transmit-control word: `tx_atten`=[20:13], `offs_div`=[12:11], `ofs_en`=[10], `tx_mode`=[9], `amps_sel`=[8], `txlo_on`=[7], `rclk_on`=[6], `test_bits`=[5:0].
  - Reference and auxiliary fields update one clock after the strobe is first seen high.
- R4: The DAC byte of a reference word goes only into a staging register. `fdac` does not change until the next main-ratio commit.
- R5: A latched main-ratio word is applied when `div_sync` is high in a clock after the strobe rise and the strobe is still high. At that same edge, `fdac` takes the staged DAC value.
- R6: `speedup` goes high one clock after a strobe rise that latched a main-ratio word. It stays high until the strobe is low, including after the commit.
- R7: A pending main-ratio commit is dropped when the strobe falls. `div_sync` has no effect in these cases:
  - while the strobe is low;
  - in the same clock as the strobe rise;
  - after the commit has already happened.
- R8: `lock_sel` selects the lock output: 00 = main AND aux AND offset, 01 = main AND aux, 10 = main only, 11 = aux only. The main, aux and offset sections are enabled by `pwr_main`, `pwr_aux` and `ofs_en`. A section whose enable is 0 reports locked.
- R9: The transmit-control word loads exactly once per strobe-high period, in the first clock the strobe is seen high.
- R10: A word with bits [23:21]=111 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Low: shift enabled; rising: load word |
| div_sync | input | 1 | Main divider terminal-count pulse |
| lock_main | input | 1 | Main loop lock flag |
| lock_aux | input | 1 | Auxiliary loop lock flag |
| lock_ofs | input | 1 | Offset loop lock flag |
| main_fmod | output | 1 | Fractional modulus select |
| main_nf | output | 3 | Fractional increment |
| main_n | output | 16 | Main divider ratio |
| ref_n | output | 10 | Reference divider ratio |
| ref_sel_main | output | 2 | Reference tap for main detector |
| ref_sel_aux | output | 2 | Reference tap for aux detector |
| fdac | output | 8 | Working compensation DAC value |
| aux_n | output | 14 | Auxiliary divider ratio |
| cp_ratio | output | 2 | Charge pump current ratio |
| lock_sel | output | 2 | Lock output source select |
| pwr_main | output | 1 | Main section enable |
| pwr_aux | output | 1 | Auxiliary section enable |
| tx_atten | output | 8 | Transmit attenuation code |
| offs_div | output | 2 | Offset loop divider select |
| ofs_en | output | 1 | Offset synthesizer enable |
| tx_mode | output | 1 | Transmit mode bit |
| amps_sel | output | 1 | Output driver linearity mode |
| txlo_on | output | 1 | Transmit LO buffer enable |
| rclk_on | output | 1 | Reference clock buffer enable |
| test_bits | output | 6 | Test field |
| speedup | output | 1 | Charge pump speed-up request |
| lock_out | output | 1 | Selected lock indication |

## Verification
Two events can land in the same clock: the divider sync pulse and a strobe transition. The bench provokes this directly. In one case it raises `div_sync` on the same edge as the strobe rise of a main-ratio word; that must leave `main_n` and `fdac` untouched while `speedup` rises. A later lone sync pulse must then commit the word. In another case it drops the strobe and then pulses sync; that must not commit, and `speedup` must be low. Random word sequences that pulse or skip the sync pulse are compared against a bench model of the staging and commit rules.

// File: rtl/prog_pkg.sv
package prog_pkg;
    localparam int WORD_W  = 24;
    localparam int DAC_W   = 8;

    typedef enum logic [2:0] {
        W_MAIN,
        W_REFDAC,
        W_AUX,
        W_CTL,
        W_NONE
    } word_kind_t;

    typedef struct packed {
        logic        fmod;
        logic [2:0]  nf;
        logic [15:0] nmain;
    } main_t;

    typedef struct packed {
        logic [9:0] nref;
        logic [1:0] sel_main;
        logic [1:0] sel_aux;
    } ref_t;

    typedef struct packed {
        logic [13:0] naux;
        logic [1:0]  cp;
        logic [1:0]  ld;
        logic        pwr_main;
        logic        pwr_aux;
    } aux_t;

    typedef struct packed {
        logic [7:0] att;
        logic [1:0] mdiv;
        logic       ofs_en;
        logic       tx_mode;
        logic       amps;
        logic       txlo_on;
        logic       rclk_on;
        logic [5:0] test;
    } ctl_t;

    function automatic word_kind_t kind_of(input logic [WORD_W-1:0] w);
        case (w[23:22])
            2'b00:   return W_MAIN;
            2'b01:   return W_REFDAC;
            2'b10:   return W_AUX;
            default: return w[21] ? W_NONE : W_CTL;
        endcase
    endfunction

    function automatic main_t main_of(input logic [WORD_W-1:0] w);
        return main_t'(w[21:2]);
    endfunction

    function automatic ref_t ref_of(input logic [WORD_W-1:0] w);
        return ref_t'(w[21:8]);
    endfunction

    function automatic logic [DAC_W-1:0] dac_of(input logic [WORD_W-1:0] w);
        return w[DAC_W-1:0];
    endfunction

    function automatic aux_t aux_of(input logic [WORD_W-1:0] w);
        return aux_t'(w[21:2]);
    endfunction

    function automatic ctl_t ctl_of(input logic [WORD_W-1:0] w);
        return ctl_t'(w[20:0]);
    endfunction
endpackage

// File: rtl/prog_shift_in.sv
module prog_shift_in
    import prog_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         ser_strobe,
    output logic [W-1:0] word_o,
    output logic         stb_rise_o
);
    logic sclk_q;
    logic stb_q;
    logic sclk_rise;

    assign sclk_rise  = ser_clk & ~sclk_q;
    assign stb_rise_o = ser_strobe & ~stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            stb_q  <= 1'b0;
            word_o <= '0;
        end else begin
            sclk_q <= ser_clk;
            stb_q  <= ser_strobe;
            if (sclk_rise && !ser_strobe)
                word_o <= {ser_data, word_o[W-1:1]};
        end
    end
endmodule

// File: rtl/prog_main_commit.sv
module prog_main_commit
    import prog_pkg::*;
#(
    parameter int DEF_NMAIN = 512,
    parameter int DEF_FDAC  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             stb_rise,
    input  logic             is_main,
    input  logic             dac_load,
    input  logic [DAC_W-1:0] dac_in,
    input  main_t            new_main,
    input  logic             div_sync,
    output main_t            main_q,
    output logic [DAC_W-1:0] fdac_q,
    output logic             speedup
);
    localparam main_t MAIN_RST = main_t'({1'b0, 3'b000, 16'(DEF_NMAIN)});

    logic             pending;
    logic [DAC_W-1:0] dac_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q    <= MAIN_RST;
            fdac_q    <= DAC_W'(DEF_FDAC);
            dac_stage <= DAC_W'(DEF_FDAC);
            pending   <= 1'b0;
            speedup   <= 1'b0;
        end else begin
            if (dac_load)
                dac_stage <= dac_in;
            if (!strobe) begin
                pending <= 1'b0;
                speedup <= 1'b0;
            end else if (stb_rise) begin
                pending <= is_main;
                speedup <= is_main;
            end else if (pending && div_sync) begin
                main_q  <= new_main;
                fdac_q  <= dac_stage;
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/prog_lock_sel.sv
module prog_lock_sel (
    input  logic [1:0] sel,
    input  logic       lock_main,
    input  logic       lock_aux,
    input  logic       lock_ofs,
    input  logic       en_main,
    input  logic       en_aux,
    input  logic       en_ofs,
    output logic       lock_o
);
    logic ok_main, ok_aux, ok_ofs;

    assign ok_main = lock_main | ~en_main;
    assign ok_aux  = lock_aux  | ~en_aux;
    assign ok_ofs  = lock_ofs  | ~en_ofs;

    always_comb begin
        case (sel)
            2'b00:   lock_o = ok_main & ok_aux & ok_ofs;
            2'b01:   lock_o = ok_main & ok_aux;
            2'b10:   lock_o = ok_main;
            default: lock_o = ok_aux;
        endcase
    end
endmodule

// File: rtl/prog_serial_regs.sv
module prog_serial_regs
    import prog_pkg::*;
#(
    parameter int DEF_NMAIN = 512,
    parameter int DEF_NREF  = 4,
    parameter int DEF_NAUX  = 128,
    parameter int DEF_FDAC  = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_strobe,
    input  logic        div_sync,
    input  logic        lock_main,
    input  logic        lock_aux,
    input  logic        lock_ofs,
    output logic        main_fmod,
    output logic [2:0]  main_nf,
    output logic [15:0] main_n,
    output logic [9:0]  ref_n,
    output logic [1:0]  ref_sel_main,
    output logic [1:0]  ref_sel_aux,
    output logic [7:0]  fdac,
    output logic [13:0] aux_n,
    output logic [1:0]  cp_ratio,
    output logic [1:0]  lock_sel,
    output logic        pwr_main,
    output logic        pwr_aux,
    output logic [7:0]  tx_atten,
    output logic [1:0]  offs_div,
    output logic        ofs_en,
    output logic        tx_mode,
    output logic        amps_sel,
    output logic        txlo_on,
    output logic        rclk_on,
    output logic [5:0]  test_bits,
    output logic        speedup,
    output logic        lock_out
);
    localparam ref_t REF_RST = ref_t'({10'(DEF_NREF), 4'b0000});
    localparam aux_t AUX_RST = aux_t'({14'(DEF_NAUX), 6'b000000});

    logic [WORD_W-1:0] word;
    logic              stb_rise;
    word_kind_t        kind;
    ref_t              ref_q;
    aux_t              aux_q;
    ctl_t              ctl_q;
    logic              ctl_guard;
    main_t             main_q;

    prog_shift_in #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_strobe (ser_strobe),
        .word_o     (word),
        .stb_rise_o (stb_rise)
    );

    assign kind = kind_of(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q     <= REF_RST;
            aux_q     <= AUX_RST;
            ctl_q     <= '0;
            ctl_guard <= 1'b0;
        end else begin
            if (stb_rise && kind == W_REFDAC)
                ref_q <= ref_of(word);
            if (stb_rise && kind == W_AUX)
                aux_q <= aux_of(word);
            if (!ser_strobe) begin
                ctl_guard <= 1'b0;
            end else if (kind == W_CTL && !ctl_guard) begin
                ctl_q     <= ctl_of(word);
                ctl_guard <= 1'b1;
            end
        end
    end

    prog_main_commit #(
        .DEF_NMAIN (DEF_NMAIN),
        .DEF_FDAC  (DEF_FDAC)
    ) u_main (
        .clk      (clk),
        .rst      (rst),
        .strobe   (ser_strobe),
        .stb_rise (stb_rise),
        .is_main  (kind == W_MAIN),
        .dac_load (stb_rise && kind == W_REFDAC),
        .dac_in   (dac_of(word)),
        .new_main (main_of(word)),
        .div_sync (div_sync),
        .main_q   (main_q),
        .fdac_q   (fdac),
        .speedup  (speedup)
    );

    prog_lock_sel u_lock (
        .sel       (aux_q.ld),
        .lock_main (lock_main),
        .lock_aux  (lock_aux),
        .lock_ofs  (lock_ofs),
        .en_main   (aux_q.pwr_main),
        .en_aux    (aux_q.pwr_aux),
        .en_ofs    (ctl_q.ofs_en),
        .lock_o    (lock_out)
    );

    assign main_fmod    = main_q.fmod;
    assign main_nf      = main_q.nf;
    assign main_n       = main_q.nmain;
    assign ref_n        = ref_q.nref;
    assign ref_sel_main = ref_q.sel_main;
    assign ref_sel_aux  = ref_q.sel_aux;
    assign aux_n        = aux_q.naux;
    assign cp_ratio     = aux_q.cp;
    assign lock_sel     = aux_q.ld;
    assign pwr_main     = aux_q.pwr_main;
    assign pwr_aux      = aux_q.pwr_aux;
    assign tx_atten     = ctl_q.att;
    assign offs_div     = ctl_q.mdiv;
    assign ofs_en       = ctl_q.ofs_en;
    assign tx_mode      = ctl_q.tx_mode;
    assign amps_sel     = ctl_q.amps;
    assign txlo_on      = ctl_q.txlo_on;
    assign rclk_on      = ctl_q.rclk_on;
    assign test_bits    = ctl_q.test;
endmodule

// File: rtl/prog_serial_regs_chk.sv
module prog_serial_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        ser_strobe,
    input logic        div_sync,
    input logic [19:0] main_bus,
    input logic [7:0]  fdac,
    input logic [20:0] ctl_bus,
    input logic        speedup,
    input logic [1:0]  lock_sel,
    input logic        pwr_main,
    input logic        pwr_aux,
    input logic        lock_out
);
    p_main_on_sync_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(main_bus) |-> ($past(div_sync) && $past(ser_strobe)));

    p_dac_with_main_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(fdac) |-> $past(div_sync));

    p_speedup_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        speedup |-> $past(ser_strobe));

    p_speedup_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !ser_strobe |=> !speedup);

    p_ctl_once_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_bus) |-> ($past(ser_strobe) && !$past(ser_strobe, 2)));

    p_main_off_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (lock_sel == 2'b10 && !pwr_main) |-> lock_out);

    p_aux_off_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (lock_sel == 2'b11 && !pwr_aux) |-> lock_out);
endmodule

bind prog_serial_regs prog_serial_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_strobe (ser_strobe),
    .div_sync   (div_sync),
    .main_bus   ({main_fmod, main_nf, main_n}),
    .fdac       (fdac),
    .ctl_bus    ({tx_atten, offs_div, ofs_en, tx_mode, amps_sel, txlo_on, rclk_on, test_bits}),
    .speedup    (speedup),
    .lock_sel   (lock_sel),
    .pwr_main   (pwr_main),
    .pwr_aux    (pwr_aux),
    .lock_out   (lock_out)
);

// File: tb/prog_serial_regs_bench.sv
module prog_serial_regs_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, div_sync = 1'b0;
    logic        lock_main = 1'b0, lock_aux = 1'b0, lock_ofs = 1'b0;
    logic        main_fmod;
    logic [2:0]  main_nf;
    logic [15:0] main_n;
    logic [9:0]  ref_n;
    logic [1:0]  ref_sel_main, ref_sel_aux;
    logic [7:0]  fdac;
    logic [13:0] aux_n;
    logic [1:0]  cp_ratio, lock_sel;
    logic        pwr_main, pwr_aux;
    logic [7:0]  tx_atten;
    logic [1:0]  offs_div;
    logic        ofs_en, tx_mode, amps_sel, txlo_on, rclk_on;
    logic [5:0]  test_bits;
    logic        speedup, lock_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [19:0] e_main  = {1'b0, 3'd0, 16'd512};
    logic [13:0] e_ref   = {10'd4, 4'd0};
    logic [7:0]  e_stage = 8'd0;
    logic [7:0]  e_dac   = 8'd0;
    logic [19:0] e_aux   = {14'd128, 6'd0};
    logic [20:0] e_ctl   = '0;

    always #10 clk = ~clk;

    prog_serial_regs u_prog_serial_regs (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_lock(input logic [1:0] sel, input logic lm, la, lo, em, ea, eo);
        logic m, a, o;
        m = lm | !em; a = la | !ea; o = lo | !eo;
        case (sel)
            2'b00:   return m & a & o;
            2'b01:   return m & a;
            2'b10:   return m;
            default: return a;
        endcase
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " main R5"}, {12'd0, main_fmod, main_nf, main_n}, {12'd0, e_main});
        chk({tag, " ref R3"}, {18'd0, ref_n, ref_sel_main, ref_sel_aux}, {18'd0, e_ref});
        chk({tag, " fdac R4"}, {24'd0, fdac}, {24'd0, e_dac});
        chk({tag, " aux R3"}, {12'd0, aux_n, cp_ratio, lock_sel, pwr_main, pwr_aux}, {12'd0, e_aux});
        chk({tag, " ctl R9"}, {11'd0, tx_atten, offs_div, ofs_en, tx_mode, amps_sel, txlo_on, rclk_on, test_bits},
            {11'd0, e_ctl});
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [23:0] w);
        shift_word(w);
        @(negedge clk); ser_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drop;
        @(negedge clk); ser_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sync;
        @(negedge clk); div_sync = 1'b1;
        @(negedge clk); div_sync = 1'b0;
    endtask

    // apply model for a word whose strobe has just risen
    task automatic model_word(input logic [23:0] w);
        case (w[23:22])
            2'b01: begin e_ref = w[21:8]; e_stage = w[7:0]; end
            2'b10: e_aux = w[21:2];
            2'b11: if (!w[21]) e_ctl = w[20:0];
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        void'($urandom(32'd1357));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_all("reset R1");
        chk("reset speedup R1", {31'd0, speedup}, 32'd0);
        chk("reset lock all off R8", {31'd0, lock_out}, 32'd1);

        // R3/R4: reference word, DAC only staged
        w = {2'b01, 10'd300, 2'b10, 2'b01, 8'hA5};
        send(w); model_word(w);
        check_all("refword R4");
        drop;

        // R3: auxiliary word powering both sections, lock select main+aux
        w = {2'b10, 14'd5000, 2'b11, 2'b01, 1'b1, 1'b1, 2'b00};
        send(w); model_word(w);
        check_all("auxword R3");
        drop;

        // R5/R6: main word waits for sync; speedup up meanwhile
        w = {2'b00, 1'b1, 3'd5, 16'd40000, 2'b00};
        send(w);
        check_all("main pending R5");
        chk("speedup pending R6", {31'd0, speedup}, 32'd1);
        pulse_sync;
        e_main = w[21:2]; e_dac = e_stage;
        check_all("main commit R5");
        chk("speedup after commit R6", {31'd0, speedup}, 32'd1);
        pulse_sync;
        check_all("second sync ignored R7");
        drop;
        chk("speedup off R6", {31'd0, speedup}, 32'd0);

        // R7: strobe falls before sync, then sync while low
        w = {2'b00, 1'b0, 3'd2, 16'd1234, 2'b00};
        send(w);
        drop;
        pulse_sync;
        check_all("dropped pending R7");
        chk("speedup low R7", {31'd0, speedup}, 32'd0);

        // R7: sync coincident with strobe rise is ignored, later sync commits
        w = {2'b00, 1'b0, 3'd7, 16'd777, 2'b00};
        shift_word(w);
        @(negedge clk); ser_strobe = 1'b1; div_sync = 1'b1;
        @(negedge clk); div_sync = 1'b0;
        check_all("sync at strobe edge R7");
        chk("speedup at edge R6", {31'd0, speedup}, 32'd1);
        pulse_sync;
        e_main = w[21:2]; e_dac = e_stage;
        check_all("late sync commit R5");
        drop;

        // R9: control word
        w = {3'b110, 8'hC3, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'h15};
        send(w); model_word(w);
        check_all("ctlword R9");
        drop;

        // R2: clocks while strobe high do not shift; re-strobe reapplies word
        w = {2'b01, 10'd999, 2'b11, 2'b00, 8'h3C};
        send(w); model_word(w);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); ser_data = ~w[i]; ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
        drop;
        @(negedge clk); ser_strobe = 1'b1;
        @(negedge clk); @(negedge clk);
        check_all("hold while strobe high R2");
        drop;

        // R10: address 111 ignored
        send({3'b111, 21'h1FFFFF});
        check_all("addr 111 R10");
        drop;

        // R8: lock select over all codes and power combinations
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 4; s++) begin
                w = {2'b10, 14'd200, 2'b01, 2'(s), p[0], p[1], 2'b00};
                send(w); model_word(w); drop;
                w = {3'b110, 8'h00, 2'b00, p[2], 1'b0, 1'b0, 1'b0, 1'b0, 6'h00};
                send(w); model_word(w); drop;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    {lock_main, lock_aux, lock_ofs} = 3'($urandom);
                    #1;
                    chk("lock select R8", {31'd0, lock_out},
                        {31'd0, exp_lock(2'(s), lock_main, lock_aux, lock_ofs, p[0], p[1], p[2])});
                end
            end
        end

        // random mix of words, main words with and without sync
        for (int it = 0; it < 40; it++) begin
            logic [2:0] kd;
            kd = 3'($urandom % 5);
            w = 24'($urandom);
            case (kd)
                3'd0: w[23:22] = 2'b00;
                3'd1: w[23:22] = 2'b01;
                3'd2: w[23:22] = 2'b10;
                3'd3: w[23:21] = 3'b110;
                default: w[23:21] = 3'b111;
            endcase
            send(w); model_word(w);
            if (kd == 3'd0) begin
                chk("random speedup R6", {31'd0, speedup}, 32'd1);
                if ($urandom % 2 == 1) begin
                    pulse_sync;
                    e_main = w[21:2]; e_dac = e_stage;
                end
            end
            drop;
            check_all("random R3");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule